// File: doc/BRIEF.md
# Debug Register File Access Controller

This block keeps the architectural debug registers of a processor core: four breakpoint address slots, a status register and a control register. Software reaches them through a 3-bit register number with separate read and write enables. Reads are combinational. Writes commit on the rising clock edge. Register numbers 4 and 5 are legacy numbers. They stand in for status and control while the debug-extensions mode input is low. While that input is high, any access to them is refused with an illegal-instruction indication.

Every write to status or control forces that register's fixed-one bits to 1. The block tells the downstream breakpoint match logic which slots must be rearmed. It does this with a one-cycle per-slot strobe, raised after a control write or after an address write to a live, non-I/O slot. It also holds a flag that is set while any enabled slot watches I/O ports. The match logic itself lies outside this block.

Control register layout, per slot i:
- bit 2i is the local enable and bit 2i+1 is the global enable. The slot counts as enabled if either bit is set.
- bits 16+4i+1 : 16+4i hold the slot's type.
- the type code 2'b10 means an I/O port watch.

Top module: `dbgreg_file`

## Requirements
- R1: After reset:
  - address slots 0..3 read 0.
  - status (number 6) reads 32'hFFFF0FF0.
  - control (number 7) reads 32'h0000_0400.
  - rearmMask and ioActive are 0, and fault is 0 when no access is made.
- R2: Numbers 0 to 3 read and write address slots 0 to 3 directly, at full width.
- R3: A write to number 6 stores wrData OR 32'hFFFF0FF0. A write to number 7 stores wrData with bit 10 forced to 1.
- R4: With deMode low, number 4 reads and writes the status register and number 5 reads and writes the control register, with the same fixed-one rules.
- R5: With deMode high, a read or write of number 4 or 5 raises fault in the same cycle and returns rdData of 0. Such a write changes no register, produces no rearm strobe and leaves ioActive unchanged.
- R6: A write to address slot i sets rearmMask to the one-hot value 1<<i in the following cycle, but only if slot i is enabled and its type is not 2'b10. Otherwise rearmMask is 0. The strobe lasts exactly one cycle.
- R7: A control write whose stored value differs from the old value only in bits 7:0 sets rearmMask, next cycle, to the slots whose enabled state (local OR global) changed.
- R8: A control write whose stored value differs from the old value in any bit above 7 sets rearmMask to 4'hF in the next cycle.
- R9: After each control write, ioActive is 1 exactly when some slot is enabled with type 2'b10. Writes to status or to address slots leave ioActive unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| deMode | input | 1 | Debug-extensions mode; high makes numbers 4 and 5 illegal |
| regNum | input | 3 | Register number for the access |
| rdEn | input | 1 | Read request (qualifies fault) |
| wrEn | input | 1 | Write request |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for regNum |
| fault | output | 1 | Illegal-instruction indication for the current access |
| rearmMask | output | 4 | One-cycle per-slot rearm strobe |
| ioActive | output | 1 | Some enabled slot watches I/O ports |

## Verification
The assertions assume that regNum, wrEn, rdEn, wrData and deMode settle before each rising edge and are known (not X) whenever an enable is high. They also assume that deMode changes only while no access is in flight. The bench drives every input on the falling edge and changes deMode only between operations with both enables low. It then samples rdData and fault a short delay after setting the inputs. It samples rearmMask and ioActive on the falling edge after the write edge.

// File: rtl/dbgreg_pkg.sv
package dbgreg_pkg;

  localparam int DBG_SLOTS = 4;
  localparam int DBG_NUM_W = 3;

  typedef struct packed {
    logic [DBG_SLOTS-1:0] addrWe;
    logic                 statusWe;
    logic                 ctrlWe;
    logic                 rdBlock;
    logic [DBG_NUM_W-1:0] effReg;
  } dbgStrobe_t;

  localparam logic [DBG_NUM_W-1:0] NUM_STATUS = 3'd6;
  localparam logic [DBG_NUM_W-1:0] NUM_CTRL   = 3'd7;
  localparam logic [DBG_NUM_W-1:0] NUM_ALIASS = 3'd4;
  localparam logic [DBG_NUM_W-1:0] NUM_ALIASC = 3'd5;

endpackage

// File: rtl/dbgreg_ctrl.sv
module dbgreg_ctrl
  import dbgreg_pkg::*;
(
  input  logic                 deMode,
  input  logic [DBG_NUM_W-1:0] regNum,
  input  logic                 rdEn,
  input  logic                 wrEn,
  output dbgStrobe_t           strobe,
  output logic                 fault
);

  logic isAlias;
  logic blocked;
  logic wrOk;
  logic [DBG_NUM_W-1:0] effReg;

  always_comb begin
    isAlias = (regNum == NUM_ALIASS) || (regNum == NUM_ALIASC);
    blocked = isAlias && deMode;
    wrOk    = wrEn && !blocked;
    effReg  = regNum;
    if (isAlias && !deMode) begin
      effReg = (regNum == NUM_ALIASS) ? NUM_STATUS : NUM_CTRL;
    end
  end

  assign fault = blocked && (rdEn || wrEn);

  genvar gi;
  generate
    for (gi = 0; gi < DBG_SLOTS; gi++) begin : g_addrWe
      assign strobe.addrWe[gi] = wrOk && (effReg == DBG_NUM_W'(gi));
    end
  endgenerate

  assign strobe.statusWe = wrOk && (effReg == NUM_STATUS);
  assign strobe.ctrlWe   = wrOk && (effReg == NUM_CTRL);
  assign strobe.rdBlock  = blocked;
  assign strobe.effReg   = effReg;

endmodule

// File: rtl/dbgreg_dpath.sv
module dbgreg_dpath
  import dbgreg_pkg::*;
#(
  parameter int               XLEN           = 32,
  parameter int               CTRL_FIXED_BIT = 10,
  parameter int               TYPE_BASE      = 16,
  parameter logic [1:0]       IO_TYPE        = 2'b10,
  parameter logic [XLEN-1:0]  STATUS_ONES    = XLEN'(32'hFFFF_0FF0)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dbgStrobe_t           strobe,
  input  logic [XLEN-1:0]      wrData,
  output logic [XLEN-1:0]      rdData,
  output logic [DBG_SLOTS-1:0] rearmMask,
  output logic                 ioActive
);

  localparam int ENABLE_BITS = 2 * DBG_SLOTS;
  localparam logic [XLEN-1:0] CTRL_ONES = XLEN'(1) << CTRL_FIXED_BIT;
  localparam logic [XLEN-1:0] LOW_MASK  = XLEN'((1 << ENABLE_BITS) - 1);

  logic [DBG_SLOTS-1:0][XLEN-1:0] addrQ;
  logic [XLEN-1:0]                statusQ;
  logic [XLEN-1:0]                ctrlQ;
  logic [DBG_SLOTS-1:0]           rearmQ;
  logic                           ioActQ;

  logic [XLEN-1:0]      newCtl;
  logic [DBG_SLOTS-1:0] enOld;
  logic [DBG_SLOTS-1:0] enNew;
  logic [DBG_SLOTS-1:0] notIoOld;
  logic [DBG_SLOTS-1:0] ioNew;
  logic [DBG_SLOTS-1:0] ctlRearm;
  logic [DBG_SLOTS-1:0] addrRearm;
  logic [DBG_SLOTS-1:0] rearmNext;
  logic                 lowOnly;

  assign newCtl = wrData | CTRL_ONES;

  genvar gs;
  generate
    for (gs = 0; gs < DBG_SLOTS; gs++) begin : g_slot
      assign enOld[gs]    = ctrlQ[2*gs] | ctrlQ[2*gs+1];
      assign enNew[gs]    = newCtl[2*gs] | newCtl[2*gs+1];
      assign notIoOld[gs] = ctrlQ[TYPE_BASE+4*gs +: 2] != IO_TYPE;
      assign ioNew[gs]    = enNew[gs] && (newCtl[TYPE_BASE+4*gs +: 2] == IO_TYPE);
      assign addrRearm[gs] = strobe.addrWe[gs] && enOld[gs] && notIoOld[gs];
    end
  endgenerate

  always_comb begin
    lowOnly   = ((ctrlQ ^ newCtl) & ~LOW_MASK) == '0;
    ctlRearm  = lowOnly ? (enOld ^ enNew) : '1;
    rearmNext = strobe.ctrlWe ? ctlRearm : addrRearm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      statusQ <= STATUS_ONES;
      ctrlQ   <= CTRL_ONES;
      rearmQ  <= '0;
      ioActQ  <= 1'b0;
    end else begin
      for (int i = 0; i < DBG_SLOTS; i++) begin
        if (strobe.addrWe[i]) addrQ[i] <= wrData;
      end
      if (strobe.statusWe) statusQ <= wrData | STATUS_ONES;
      if (strobe.ctrlWe) begin
        ctrlQ  <= newCtl;
        ioActQ <= |ioNew;
      end
      rearmQ <= rearmNext;
    end
  end

  always_comb begin
    rdData = '0;
    if (!strobe.rdBlock) begin
      if (strobe.effReg == NUM_STATUS) begin
        rdData = statusQ;
      end else if (strobe.effReg == NUM_CTRL) begin
        rdData = ctrlQ;
      end else begin
        for (int i = 0; i < DBG_SLOTS; i++) begin
          if (strobe.effReg == DBG_NUM_W'(i)) rdData = addrQ[i];
        end
      end
    end
  end

  assign rearmMask = rearmQ;
  assign ioActive  = ioActQ;

endmodule

// File: rtl/dbgreg_file.sv
module dbgreg_file
  import dbgreg_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] STATUS_ONES = XLEN'(32'hFFFF_0FF0)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 deMode,
  input  logic [DBG_NUM_W-1:0] regNum,
  input  logic                 rdEn,
  input  logic                 wrEn,
  input  logic [XLEN-1:0]      wrData,
  output logic [XLEN-1:0]      rdData,
  output logic                 fault,
  output logic [DBG_SLOTS-1:0] rearmMask,
  output logic                 ioActive
);

  dbgStrobe_t strobe;

  dbgreg_ctrl u_ctrl (
    .deMode (deMode),
    .regNum (regNum),
    .rdEn   (rdEn),
    .wrEn   (wrEn),
    .strobe (strobe),
    .fault  (fault)
  );

  dbgreg_dpath #(
    .XLEN        (XLEN),
    .STATUS_ONES (STATUS_ONES)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .wrData    (wrData),
    .rdData    (rdData),
    .rearmMask (rearmMask),
    .ioActive  (ioActive)
  );

endmodule

// File: rtl/dbgreg_file_chk.sv
module dbgreg_file_chk
  import dbgreg_pkg::*;
#(
  parameter int              XLEN        = 32,
  parameter logic [XLEN-1:0] STATUS_ONES = XLEN'(32'hFFFF_0FF0)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 deMode,
  input logic [DBG_NUM_W-1:0] regNum,
  input logic                 rdEn,
  input logic                 wrEn,
  input logic [XLEN-1:0]      wrData,
  input logic [XLEN-1:0]      rdData,
  input logic                 fault,
  input logic [DBG_SLOTS-1:0] rearmMask,
  input logic                 ioActive
);

  logic ctrlWrite;
  assign ctrlWrite = wrEn && !fault && (regNum == 3'd7 || (regNum == 3'd5 && !deMode));

  a_r5_fault_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> rdData == '0);

  a_r5_fault_no_rearm: assert property (@(posedge clk) disable iff (!rstN)
    (fault && wrEn) |=> rearmMask == '0);

  a_r5_fault_io_stable: assert property (@(posedge clk) disable iff (!rstN)
    (fault && wrEn) |=> $stable(ioActive));

  a_r6_addr_onehot: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regNum < 3'd4) |=> $onehot0(rearmMask));

  a_r6_idle_no_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> rearmMask == '0);

  a_r9_io_held: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrite |=> $stable(ioActive));

  a_r3_ctrl_fixed_bit: assert property (@(posedge clk) disable iff (!rstN)
    (regNum == 3'd7) |-> rdData[10]);

  a_r3_status_fixed_bits: assert property (@(posedge clk) disable iff (!rstN)
    (regNum == 3'd6) |-> (rdData & STATUS_ONES) == STATUS_ONES);

endmodule

bind dbgreg_file dbgreg_file_chk #(.XLEN(XLEN), .STATUS_ONES(STATUS_ONES)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .deMode    (deMode),
  .regNum    (regNum),
  .rdEn      (rdEn),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .rdData    (rdData),
  .fault     (fault),
  .rearmMask (rearmMask),
  .ioActive  (ioActive)
);

// File: tb/dbgreg_file_bench.sv
module dbgreg_file_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        deMode = 1'b0;
  logic [2:0]  regNum = '0;
  logic        rdEn = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        fault;
  logic [3:0]  rearmMask;
  logic        ioActive;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [3:0]  gotRearm;
  logic        gotIo;
  logic        gotFault;
  logic [31:0] gotRd;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbgreg_file u_dbgreg_file (
    .clk(clk), .rstN(rstN), .deMode(deMode), .regNum(regNum), .rdEn(rdEn),
    .wrEn(wrEn), .wrData(wrData), .rdData(rdData), .fault(fault),
    .rearmMask(rearmMask), .ioActive(ioActive)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic readReg(logic [2:0] n);
    @(negedge clk);
    regNum = n; rdEn = 1'b1;
    #1;
    gotRd = rdData; gotFault = fault;
    rdEn = 1'b0;
  endtask

  task automatic writeReg(logic [2:0] n, logic [31:0] d);
    @(negedge clk);
    regNum = n; wrData = d; wrEn = 1'b1;
    #1;
    gotFault = fault;
    @(negedge clk);
    gotRearm = rearmMask; gotIo = ioActive;
    wrEn = 1'b0;
  endtask

  task automatic t_reset;
    for (int i = 0; i < 4; i++) begin
      readReg(3'(i)); check("R1 addr reset", gotRd, 32'h0);
    end
    readReg(3'd6); check("R1 status reset", gotRd, 32'hFFFF0FF0);
    readReg(3'd7); check("R1 ctrl reset", gotRd, 32'h0000_0400);
    check("R1 rearm reset", 32'(rearmMask), 32'h0);
    check("R1 io reset", 32'(ioActive), 32'h0);
    check("R1 fault idle", 32'(gotFault), 32'h0);
  endtask

  task automatic t_addr;
    for (int i = 0; i < 4; i++) begin
      writeReg(3'(i), 32'hA5A5_0000 + 32'(i * 17));
      check("R6 disabled slot no strobe", 32'(gotRearm), 32'h0);
    end
    for (int i = 0; i < 4; i++) begin
      readReg(3'(i)); check("R2 addr readback", gotRd, 32'hA5A5_0000 + 32'(i * 17));
    end
    writeReg(3'd3, 32'hFFFF_FFFF);
    readReg(3'd3); check("R2 full width", gotRd, 32'hFFFF_FFFF);
  endtask

  task automatic t_fixed;
    writeReg(3'd6, 32'h0);
    readReg(3'd6); check("R3 status ones", gotRd, 32'hFFFF0FF0);
    writeReg(3'd6, 32'h0000_F00F);
    readReg(3'd6); check("R3 status or", gotRd, 32'hFFFF_FFFF);
    writeReg(3'd7, 32'h0);
    readReg(3'd7); check("R3 ctrl bit10", gotRd, 32'h0000_0400);
    check("R7 no change no strobe", 32'(gotRearm), 32'h0);
  endtask

  task automatic t_alias;
    deMode = 1'b0;
    writeReg(3'd4, 32'h1);
    readReg(3'd6); check("R4 alias4 write", gotRd, 32'hFFFF0FF1);
    readReg(3'd4); check("R4 alias4 read", gotRd, 32'hFFFF0FF1);
    writeReg(3'd5, 32'h3);
    check("R7 slot0 flip via alias", 32'(gotRearm), 32'h1);
    readReg(3'd7); check("R4 alias5 write", gotRd, 32'h0000_0403);
    readReg(3'd5); check("R4 alias5 read", gotRd, 32'h0000_0403);
  endtask

  task automatic t_fault;
    deMode = 1'b1;
    readReg(3'd4);
    check("R5 read fault", 32'(gotFault), 32'h1);
    check("R5 read zero", gotRd, 32'h0);
    readReg(3'd5); check("R5 read5 fault", 32'(gotFault), 32'h1);
    writeReg(3'd5, 32'hFFFF_FFFF);
    check("R5 write fault", 32'(gotFault), 32'h1);
    check("R5 no strobe", 32'(gotRearm), 32'h0);
    check("R5 io unchanged", 32'(gotIo), 32'h0);
    writeReg(3'd4, 32'h0000_F000);
    check("R5 write4 fault", 32'(gotFault), 32'h1);
    readReg(3'd6); check("R5 num6 legal", 32'(gotFault), 32'h0);
    deMode = 1'b0;
    readReg(3'd7); check("R5 ctrl unchanged", gotRd, 32'h0000_0403);
    readReg(3'd6); check("R5 status unchanged", gotRd, 32'hFFFF0FF1);
  endtask

  task automatic t_ctrl;
    writeReg(3'd7, 32'h0000_000C);
    check("R7 two flips", 32'(gotRearm), 32'h3);
    writeReg(3'd7, 32'h0000_0008);
    check("R7 global only no flip", 32'(gotRearm), 32'h0);
    writeReg(3'd7, 32'h0020_0008);
    check("R8 high bits all", 32'(gotRearm), 32'hF);
    check("R9 io set", 32'(gotIo), 32'h1);
    writeReg(3'd1, 32'h0000_0060);
    check("R6 io slot no strobe", 32'(gotRearm), 32'h0);
    writeReg(3'd6, 32'h0);
    check("R9 status write keeps io", 32'(gotIo), 32'h1);
    writeReg(3'd7, 32'h0020_0000);
    check("R7 slot1 flip", 32'(gotRearm), 32'h2);
    check("R9 io cleared", 32'(gotIo), 32'h0);
    writeReg(3'd7, 32'h0100_0010);
    check("R8 type change all", 32'(gotRearm), 32'hF);
    check("R9 non-io slot", 32'(gotIo), 32'h0);
    writeReg(3'd2, 32'h1234_5678);
    check("R6 live slot strobe", 32'(gotRearm), 32'h4);
    @(negedge clk);
    check("R6 one-cycle pulse", 32'(rearmMask), 32'h0);
    writeReg(3'd3, 32'h0);
    check("R6 disabled slot3", 32'(gotRearm), 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset;
    t_addr;
    t_fixed;
    t_alias;
    t_fault;
    t_ctrl;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule